// File: doc/BRIEF.md
# Viterbi Frame Traceback and Bit Reordering Unit

This block sits behind the add-compare-select array of a 64-state, rate-1/2, constraint-length-7 Viterbi decoder that works one frame at a time. For every trellis stage the ACS array hands over a decision vector with one bit per state. The block stores the vector in the next column of its survivor storage. When the final stage of a frame has arrived, the block walks the stored decisions backwards, starting from the all-zero state that the encoder's zero tail forces.

The walk produces the decoded bits last-first. Each kept bit is pushed onto a bit stack. The stack is then drained, so the payload comes out in transmission order, with the final payload bit flagged. The zero tail stages that flush the encoder are not sent to the output. While the walk and the drain are under way the block raises `busy` and ignores any new decision vectors. Frames may be up to `MAX_STAGES` stages long, tail included.

Top module: `vtb_traceback_top`

## Requirements
- R1: After reset, `bit_vld`, `bit_eof` and `busy` are all low.
- R2: While `busy` is low, each cycle with `dec_vld` high stores `dec_vec` as the next trellis stage. The first such cycle after reset, or after a frame has finished, is stage 0. Bit s of `dec_vec` is the decision for state s.
- R3: A cycle with `dec_vld` and `dec_last` both high, while `busy` is low, supplies the final stage of the frame. `busy` is high in the following cycle, and the traceback starts at that final stage in state 0.
- R4: A state is a 6-bit value whose bit 0 holds the newest input bit. At each stage k, taken from last to first, the decoded bit is bit 0 of the current state. With d the stored decision for the current state at stage k, the state for stage k-1 is {d, current[5:1]}.
- R5: The decoded bits leave on `bit_data`, qualified by `bit_vld`, in forward order: stage 0 first. During output, `bit_vld` is high in consecutive cycles.
- R6: A frame of N stages yields exactly N-6 output bits, because the last six stages are treated as tail and dropped. A frame of six stages or fewer yields no output.
- R7: `bit_eof` is high together with `bit_vld` on the last output bit of a frame and at no other time.
- R8: While `busy` is high, `dec_vld` and `dec_last` have no effect. The frame in progress still decodes correctly, and no extra frame is started.
- R9: `bit_vld` is only high in the cycle after a cycle in which `busy` was high. `busy` returns low once the frame's output is complete, and a new frame is accepted from then on. Frames of up to `MAX_STAGES` stages decode correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_vld | input | 1 | Decision vector valid for one trellis stage |
| dec_last | input | 1 | Marks the stage given with `dec_vld` as the frame's final stage |
| dec_vec | input | 64 | Decision bit per state; bit s belongs to state s |
| bit_vld | output | 1 | Decoded bit valid |
| bit_data | output | 1 | Decoded bit, in forward order |
| bit_eof | output | 1 | Marks the last decoded bit of a frame |
| busy | output | 1 | Traceback or output running; inputs are ignored |

## Verification
On every cycle the assertions check three things: that a frame end raises `busy`; that `bit_eof` only appears on a valid bit and is followed by a gap; and that output only follows a busy cycle. They cannot tell whether a decoded bit is right. For that the bench encodes known payloads through the trellis, surrounds the true path with random decisions, and compares every output bit and flag in order. Only these scenarios show correct bit order, tail removal, the short and maximum-length frames, and that stray vectors sent during a busy period have no effect.

// File: rtl/vtb_pkg.sv
package vtb_pkg;

   typedef enum logic [1:0] {
      PH_COLLECT = 2'd0,
      PH_TRACE   = 2'd1,
      PH_EMIT    = 2'd2
   } vtb_phase_e;

endpackage

// File: rtl/vtb_surv_mem.sv
module vtb_surv_mem #(
   parameter int NUM_STATES = 64,
   parameter int DEPTH      = 256,
   parameter int SW         = 6,
   parameter int AW         = 8
) (
   input  logic                  clk,
   input  logic                  wr_en,
   input  logic [AW-1:0]         wr_addr,
   input  logic [NUM_STATES-1:0] wr_vec,
   input  logic [AW-1:0]         rd_addr,
   input  logic [SW-1:0]         rd_state,
   output logic                  rd_bit
);

   logic [NUM_STATES-1:0] col_q [DEPTH];
   logic [NUM_STATES-1:0] rd_col;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         col_q[wr_addr] <= wr_vec;
      end
   end

   always_comb begin
      rd_col = col_q[rd_addr];
      rd_bit = rd_col[rd_state];
   end

endmodule

// File: rtl/vtb_lifo.sv
module vtb_lifo #(
   parameter int DEPTH = 256,
   parameter int AW    = 8,
   parameter int CW    = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_en,
   input  logic          push_bit,
   input  logic          pop_en,
   output logic          out_vld,
   output logic          out_bit,
   output logic          out_eof,
   output logic [CW-1:0] fill
);

   logic [DEPTH-1:0] stack_q;
   logic [CW-1:0]    fill_q;
   logic [CW-1:0]    top_idx;

   assign top_idx = fill_q - CW'(1);
   assign fill    = fill_q;

   always_ff @(posedge clk) begin
      if (push_en) begin
         stack_q[fill_q[AW-1:0]] <= push_bit;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_q  <= '0;
         out_vld <= 1'b0;
         out_bit <= 1'b0;
         out_eof <= 1'b0;
      end else begin
         out_vld <= pop_en;
         if (push_en) begin
            fill_q <= fill_q + CW'(1);
         end else if (pop_en) begin
            fill_q  <= top_idx;
            out_bit <= stack_q[top_idx[AW-1:0]];
            out_eof <= (fill_q == CW'(1));
         end
         if (!pop_en) begin
            out_eof <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/vtb_trace.sv
module vtb_trace
   import vtb_pkg::*;
#(
   parameter int SW       = 6,
   parameter int TAIL_LEN = 6,
   parameter int AW       = 8,
   parameter int CW       = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dec_vld,
   input  logic          dec_last,
   input  logic          rd_bit,
   input  logic [CW-1:0] lifo_fill,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] rd_addr,
   output logic [SW-1:0] rd_state,
   output logic          push_en,
   output logic          push_bit,
   output logic          pop_en,
   output logic          busy
);

   vtb_phase_e    phase_q;
   logic [AW-1:0] wptr_q;
   logic [AW-1:0] tptr_q;
   logic [AW-1:0] last_q;
   logic [SW-1:0] state_q;
   logic          keep_stage;

   always_comb begin
      keep_stage = (CW'(tptr_q) + CW'(TAIL_LEN)) <= CW'(last_q);
      wr_en      = (phase_q == PH_COLLECT) && dec_vld;
      wr_addr    = wptr_q;
      rd_addr    = tptr_q;
      rd_state   = state_q;
      push_en    = (phase_q == PH_TRACE) && keep_stage;
      push_bit   = state_q[0];
      pop_en     = (phase_q == PH_EMIT) && (lifo_fill != '0);
      busy       = (phase_q != PH_COLLECT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_COLLECT;
         wptr_q  <= '0;
         tptr_q  <= '0;
         last_q  <= '0;
         state_q <= '0;
      end else begin
         unique case (phase_q)
            PH_COLLECT: begin
               if (dec_vld) begin
                  if (dec_last) begin
                     phase_q <= PH_TRACE;
                     tptr_q  <= wptr_q;
                     last_q  <= wptr_q;
                     state_q <= '0;
                     wptr_q  <= '0;
                  end else begin
                     wptr_q  <= wptr_q + AW'(1);
                  end
               end
            end
            PH_TRACE: begin
               state_q <= {rd_bit, state_q[SW-1:1]};
               if (tptr_q == '0) begin
                  phase_q <= PH_EMIT;
               end else begin
                  tptr_q  <= tptr_q - AW'(1);
               end
            end
            PH_EMIT: begin
               if (lifo_fill <= CW'(1)) begin
                  phase_q <= PH_COLLECT;
               end
            end
            default: phase_q <= PH_COLLECT;
         endcase
      end
   end

endmodule

// File: rtl/vtb_traceback_top.sv
module vtb_traceback_top #(
   parameter int ST_BITS    = 6,
   parameter int MAX_STAGES = 256
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    dec_vld,
   input  logic                    dec_last,
   input  logic [(1<<ST_BITS)-1:0] dec_vec,
   output logic                    bit_vld,
   output logic                    bit_data,
   output logic                    bit_eof,
   output logic                    busy
);

   localparam int NUM_STATES = 1 << ST_BITS;
   localparam int TAIL_LEN   = ST_BITS;
   localparam int AW         = (MAX_STAGES > 1) ? $clog2(MAX_STAGES) : 1;
   localparam int CW         = AW + 1;

   generate
      if (ST_BITS < 2 || ST_BITS > 8) begin : g_bad_states
         $error("ST_BITS must lie between 2 and 8");
      end
      if (MAX_STAGES <= TAIL_LEN) begin : g_bad_depth
         $error("MAX_STAGES must exceed the tail length");
      end
   endgenerate

   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [AW-1:0] rd_addr;
   logic [ST_BITS-1:0] rd_state;
   logic          rd_bit;
   logic          push_en;
   logic          push_bit;
   logic          pop_en;
   logic [CW-1:0] lifo_fill;

   vtb_trace #(
      .SW(ST_BITS), .TAIL_LEN(TAIL_LEN), .AW(AW), .CW(CW)
   ) u_trace (
      .clk(clk), .rst_n(rst_n),
      .dec_vld(dec_vld), .dec_last(dec_last),
      .rd_bit(rd_bit), .lifo_fill(lifo_fill),
      .wr_en(wr_en), .wr_addr(wr_addr),
      .rd_addr(rd_addr), .rd_state(rd_state),
      .push_en(push_en), .push_bit(push_bit),
      .pop_en(pop_en), .busy(busy)
   );

   vtb_surv_mem #(
      .NUM_STATES(NUM_STATES), .DEPTH(MAX_STAGES), .SW(ST_BITS), .AW(AW)
   ) u_mem (
      .clk(clk),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_vec(dec_vec),
      .rd_addr(rd_addr), .rd_state(rd_state), .rd_bit(rd_bit)
   );

   vtb_lifo #(
      .DEPTH(MAX_STAGES), .AW(AW), .CW(CW)
   ) u_lifo (
      .clk(clk), .rst_n(rst_n),
      .push_en(push_en), .push_bit(push_bit), .pop_en(pop_en),
      .out_vld(bit_vld), .out_bit(bit_data), .out_eof(bit_eof),
      .fill(lifo_fill)
   );

endmodule

// File: rtl/vtb_checker.sv
module vtb_checker (
   input logic clk,
   input logic rst_n,
   input logic dec_vld,
   input logic dec_last,
   input logic busy,
   input logic bit_vld,
   input logic bit_eof
);

   AST_FRAME_END_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && dec_last && !busy) |=> busy) else $error("frame end without busy"); // R3

   AST_EOF_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      bit_eof |-> bit_vld) else $error("eof without valid"); // R7

   AST_EOF_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      bit_eof |=> !bit_vld) else $error("output continues after eof"); // R7

   AST_OUT_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld |-> $past(busy)) else $error("output outside busy window"); // R9

endmodule

bind vtb_traceback_top vtb_checker u_vtb_checker (
   .clk(clk), .rst_n(rst_n), .dec_vld(dec_vld), .dec_last(dec_last),
   .busy(busy), .bit_vld(bit_vld), .bit_eof(bit_eof)
);

// File: tb/tb_vtb_traceback_top.sv
module tb_vtb_traceback_top;

   localparam int SB = 6;
   localparam int NS = 64;
   localparam int MAXS = 256;

   typedef struct packed { logic d; logic e; } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dec_vld = 1'b0;
   logic dec_last = 1'b0;
   logic [NS-1:0] dec_vec = '0;
   logic bit_vld, bit_data, bit_eof, busy;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   exp_t expq[$];

   always #10 clk = ~clk;

   vtb_traceback_top #(.ST_BITS(SB), .MAX_STAGES(MAXS)) dut (
      .clk(clk), .rst_n(rst_n), .dec_vld(dec_vld), .dec_last(dec_last),
      .dec_vec(dec_vec), .bit_vld(bit_vld), .bit_data(bit_data),
      .bit_eof(bit_eof), .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: R5 R7 ordering and flags
   always @(negedge clk) begin
      if (rst_n && bit_vld) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R6 unexpected output bit", 1, 0);
         end else begin
            exp_t e;
            e = expq.pop_front();
            chk(bit_data == e.d, "R4/R5 decoded bit", int'(bit_data), int'(e.d));
            chk(bit_eof == e.e, "R7 end flag", int'(bit_eof), int'(e.e));
         end
      end else if (rst_n && bit_eof) begin
         chk(1'b0, "R7 eof without valid", 1, 0);
      end
   end

   task automatic wait_idle();
      int t = 0;
      while (busy && t < 2000) begin
         @(negedge clk);
         t++;
      end
      chk(!busy, "R9 busy returns low", int'(busy), 0);
   endtask

   // mode 0 random, 1 all ones, 2 alternating; stray drives inputs while busy (R8)
   task automatic send_frame(input int ndata, input int mode, input bit stray);
      int n = ndata + SB;
      logic [SB-1:0] st = '0;
      for (int k = 0; k < n; k++) begin
         logic u;
         logic [SB-1:0] nx;
         logic [NS-1:0] v;
         if (k >= ndata) u = 1'b0;
         else if (mode == 1) u = 1'b1;
         else if (mode == 2) u = k[0];
         else u = 1'($urandom_range(0, 1));
         nx = {st[SB-2:0], u};
         v = {$urandom(), $urandom()};
         v[nx] = st[SB-1];
         if (k < ndata) expq.push_back('{d: u, e: (k == ndata - 1)});
         @(negedge clk);
         dec_vld  = 1'b1;
         dec_vec  = v;
         dec_last = (k == n - 1);
         st = nx;
      end
      @(negedge clk);
      dec_vld  = 1'b0;
      dec_last = 1'b0;
      chk(busy, "R3 busy after frame end", int'(busy), 1);
      if (stray) begin
         for (int j = 0; j < 12; j++) begin
            dec_vld  = 1'b1;
            dec_last = j[0];
            dec_vec  = {$urandom(), $urandom()};
            @(negedge clk);
         end
         dec_vld  = 1'b0;
         dec_last = 1'b0;
      end
      wait_idle();
      repeat (2) @(negedge clk);
      chk(expq.size() == 0, "R6 output count", expq.size(), 0);
      chk(!busy, "R8 no extra frame started", int'(busy), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!bit_vld, "R1 bit_vld in reset", int'(bit_vld), 0);
      chk(!bit_eof, "R1 bit_eof in reset", int'(bit_eof), 0);
      chk(!busy, "R1 busy in reset", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !bit_vld, "R1 idle after reset", int'(busy), 0);

      send_frame(20, 0, 1'b0);           // R2 R4 R5 basic
      send_frame(1, 0, 1'b0);            // R6 single payload bit
      send_frame(0, 0, 1'b0);            // R6 tail only, no output
      send_frame(30, 1, 1'b0);           // R4 all ones
      send_frame(40, 2, 1'b1);           // R8 stray inputs while busy
      send_frame(MAXS - SB, 0, 1'b0);    // R9 maximum frame
      send_frame(15, 0, 1'b0);           // R9 back to back

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule